// File: doc/BRIEF.md
# JTAG Debug-Port Access Register

This block is the target-side data-register logic that sits behind a JTAG TAP controller in a debug port. The TAP controller is outside the block. It supplies its capture, shift and update strobes together with the current instruction value. From these the block selects one of four data registers: an abort register, a debug-port access register, an access-port access register and a fixed identification register. The two access registers share a 35-bit scan path. Software shifts in a request made of three control bits followed by a 32-bit data word. In the same scan it shifts out a 3-bit acknowledge and the posted result of the read that came before.

Accepted requests are issued as one-cycle pulses on a simple internal register-request port to a register bank. The bank answers with busy, read data and an error flag. Reads are posted: the data of a read comes back on a later scan, never on the scan that issued it. While an access is still in flight the block answers WAIT and drops the new request. Two sticky flags record bank errors and overruns. While either flag is set, access-port traffic is suppressed. The abort register cancels a pending access and clears the sticky flags.

Top module: `dp_access_top`

## Requirements
- R1: With instruction 0xE, capture loads the 32-bit parameter IDCODE_VAL, whose bit 0 is 1, and shifting returns it LSB first on tdo_o.
- R2: The scan register is 35 bits long and is shifted LSB first, with tdo_o showing bit 0 before each shift. After the shift, bit 0 is the read flag (1 = read, 0 = write), bits 2:1 are the register address and bits 34:3 are the data word.
- R3: With instruction 0x8, 0xA or 0xB, capture loads the acknowledge into bits 2:0 and the posted read word into bits 34:3. The acknowledge is 3'b010 (OK) when no access is pending and 3'b001 (WAIT) when one is.
- R4: An update with instruction 0xA or 0xB whose capture gave OK drives req_o high for exactly the one cycle after the update cycle. In that cycle req_ap_o is 1 for 0xB and 0 for 0xA, req_write_o is the inverse of the read flag, and req_addr_o and req_wdata_o carry the scanned fields.
- R5: The word of a completed read is latched as the posted word. It is returned in bits 34:3 of the next scan whose capture follows the completion.
- R6: A read with instruction 0xA at address 3 (the read buffer) issues no request and leaves the posted word unchanged.
- R7: A request whose capture gave WAIT is discarded: no request is issued and its write data is lost.
- R8: A discarded WAIT request sets sticky_orun_o when orun_det_en_i is 1, and leaves it unchanged when orun_det_en_i is 0.
- R9: An access that completes (busy_i low after the request) with error_i high sets sticky_err_o.
- R10: While sticky_err_o or sticky_orun_o is set, requests under instruction 0xB are ignored, while requests under 0xA are still issued.
- R11: An update with instruction 0x8 acts on the data bits. Data bit 0 cancels the pending access, so the next capture acknowledges OK, and pulses abort_o for one cycle. Data bit 1 clears sticky_err_o. Data bit 2 clears sticky_orun_o. An update under any instruction other than 0x8, 0xA, 0xB or 0xE changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_i | input | 4 | Current TAP instruction value |
| capture_dr_i | input | 1 | Capture-DR strobe |
| shift_dr_i | input | 1 | Shift-DR strobe |
| update_dr_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0 of the scan register) |
| orun_det_en_i | input | 1 | Enables the overrun sticky flag |
| req_o | output | 1 | One-cycle register request pulse |
| req_ap_o | output | 1 | 1 = access-port target, 0 = debug-port target |
| req_addr_o | output | 2 | Register address of the request |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_wdata_o | output | 32 | Write data of the request |
| abort_o | output | 1 | One-cycle cancel pulse to the register bank |
| busy_i | input | 1 | Register bank still working on the request |
| rdata_i | input | 32 | Read data from the bank, valid when busy_i is low |
| error_i | input | 1 | Bank error for the access, valid when busy_i is low |
| sticky_err_o | output | 1 | Sticky bank-error flag |
| sticky_orun_o | output | 1 | Sticky overrun flag |

## Verification
The capture edge loads the scan register, so tdo_o shows its bit 0 from then until the first shift edge. The request pulse and abort_o appear in the cycle after the update cycle. Sticky-flag changes take effect at the update edge, and an error at the completion edge. A read completes at the first edge after the request cycle at which busy_i is low; the posted word is therefore visible only to a scan captured after that edge. The bench's reference model advances on the same edges and is compared at every falling edge. The scenario checks wait a fixed number of idle cycles after each scan so that the bank's programmed delay has either clearly passed or clearly not passed.

// File: rtl/dp_access_pkg.sv
package dp_access_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int IR_W   = 4;
    localparam int ACK_W  = 3;
    localparam int SCAN_W = DATA_W + ADDR_W + 1;

    localparam logic [IR_W-1:0] IR_ABORT  = 4'h8;
    localparam logic [IR_W-1:0] IR_DPACC  = 4'hA;
    localparam logic [IR_W-1:0] IR_APACC  = 4'hB;
    localparam logic [IR_W-1:0] IR_IDCODE = 4'hE;

    localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

    localparam logic [ADDR_W-1:0] RDBUF_ADDR = 2'd3;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ABORT, SEL_DPACC, SEL_APACC, SEL_IDCODE
    } dr_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              rnw;
    } scan_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] posted;
        logic [ACK_W-1:0]  ack;
    } scan_rsp_t;

    typedef struct packed {
        logic              ap;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bank_req_t;

    function automatic logic [ACK_W-1:0] ack_for(input logic pending);
        return pending ? ACK_WAIT : ACK_OK;
    endfunction
endpackage

// File: rtl/dp_ir_decode.sv
module dp_ir_decode
    import dp_access_pkg::*;
(
    input  logic [IR_W-1:0] ir_i,
    output dr_sel_e         sel_o
);
    always_comb begin
        unique case (ir_i)
            IR_ABORT:  sel_o = SEL_ABORT;
            IR_DPACC:  sel_o = SEL_DPACC;
            IR_APACC:  sel_o = SEL_APACC;
            IR_IDCODE: sel_o = SEL_IDCODE;
            default:   sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/dp_scan_reg.sv
module dp_scan_reg
    import dp_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              tdi_i,
    input  logic [SCAN_W-1:0] cap_val_i,
    output logic [SCAN_W-1:0] sr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_o <= '0;
        end else if (capture_i) begin
            sr_o <= cap_val_i;
        end else if (shift_i) begin
            sr_o <= {tdi_i, sr_o[SCAN_W-1:1]};
        end
    end
endmodule

// File: rtl/dp_access_ctrl.sv
module dp_access_ctrl
    import dp_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dr_sel_e           sel_i,
    input  logic              capture_i,
    input  logic              update_i,
    input  scan_req_t         scan_i,
    input  logic              orun_det_en_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              error_i,
    output logic              req_o,
    output bank_req_t         breq_o,
    output logic              abort_o,
    output logic              pend_o,
    output logic [DATA_W-1:0] posted_o,
    output logic              serr_o,
    output logic              sorun_o
);
    localparam int ABT_CANCEL = 0;
    localparam int ABT_CLRERR = 1;
    localparam int ABT_CLRORN = 2;

    logic ack_ok_q;
    logic pend_rd_q;
    logic is_ap;
    logic rdbuf_hit;
    logic ap_blocked;
    logic launch_ok;
    logic completes;

    always_comb begin
        is_ap      = (sel_i == SEL_APACC);
        rdbuf_hit  = !is_ap && scan_i.rnw && (scan_i.addr == RDBUF_ADDR);
        ap_blocked = is_ap && (serr_o || sorun_o);
        launch_ok  = !rdbuf_hit && !ap_blocked;
        completes  = pend_o && !req_o && !busy_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_ok_q  <= 1'b1;
            pend_o    <= 1'b0;
            pend_rd_q <= 1'b0;
            posted_o  <= '0;
            serr_o    <= 1'b0;
            sorun_o   <= 1'b0;
            req_o     <= 1'b0;
            abort_o   <= 1'b0;
            breq_o    <= '0;
        end else begin
            req_o   <= 1'b0;
            abort_o <= 1'b0;
            if (capture_i) begin
                ack_ok_q <= !pend_o;
            end
            if (completes) begin
                pend_o <= 1'b0;
                if (pend_rd_q) begin
                    posted_o <= rdata_i;
                end
                if (error_i) begin
                    serr_o <= 1'b1;
                end
            end
            if (update_i) begin
                unique case (sel_i)
                    SEL_DPACC, SEL_APACC: begin
                        if (!ack_ok_q) begin
                            if (orun_det_en_i) begin
                                sorun_o <= 1'b1;
                            end
                        end else if (launch_ok) begin
                            req_o        <= 1'b1;
                            breq_o.ap    <= is_ap;
                            breq_o.write <= !scan_i.rnw;
                            breq_o.addr  <= scan_i.addr;
                            breq_o.wdata <= scan_i.data;
                            pend_o       <= 1'b1;
                            pend_rd_q    <= scan_i.rnw;
                        end
                    end
                    SEL_ABORT: begin
                        if (scan_i.data[ABT_CANCEL]) begin
                            pend_o  <= 1'b0;
                            abort_o <= 1'b1;
                        end
                        if (scan_i.data[ABT_CLRERR]) begin
                            serr_o <= 1'b0;
                        end
                        if (scan_i.data[ABT_CLRORN]) begin
                            sorun_o <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dp_access_top.sv
module dp_access_top
    import dp_access_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h0C0F_FEE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_i,
    input  logic              capture_dr_i,
    input  logic              shift_dr_i,
    input  logic              update_dr_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    input  logic              orun_det_en_i,
    output logic              req_o,
    output logic              req_ap_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              req_write_o,
    output logic [DATA_W-1:0] req_wdata_o,
    output logic              abort_o,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              error_i,
    output logic              sticky_err_o,
    output logic              sticky_orun_o
);
    dr_sel_e           sel;
    logic [SCAN_W-1:0] sr;
    logic [SCAN_W-1:0] cap_val;
    logic              pend;
    logic [DATA_W-1:0] posted;
    bank_req_t         breq;
    scan_rsp_t         rsp;

    dp_ir_decode u_dec (
        .ir_i  (ir_i),
        .sel_o (sel)
    );

    always_comb begin
        rsp.posted = posted;
        rsp.ack    = ack_for(pend);
        unique case (sel)
            SEL_ABORT, SEL_DPACC, SEL_APACC: cap_val = rsp;
            SEL_IDCODE:                      cap_val = SCAN_W'(IDCODE_VAL);
            default:                         cap_val = '0;
        endcase
    end

    dp_scan_reg u_sr (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture_dr_i),
        .shift_i   (shift_dr_i),
        .tdi_i     (tdi_i),
        .cap_val_i (cap_val),
        .sr_o      (sr)
    );

    dp_access_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .sel_i         (sel),
        .capture_i     (capture_dr_i),
        .update_i      (update_dr_i),
        .scan_i        (scan_req_t'(sr)),
        .orun_det_en_i (orun_det_en_i),
        .busy_i        (busy_i),
        .rdata_i       (rdata_i),
        .error_i       (error_i),
        .req_o         (req_o),
        .breq_o        (breq),
        .abort_o       (abort_o),
        .pend_o        (pend),
        .posted_o      (posted),
        .serr_o        (sticky_err_o),
        .sorun_o       (sticky_orun_o)
    );

    assign tdo_o       = sr[0];
    assign req_ap_o    = breq.ap;
    assign req_addr_o  = breq.addr;
    assign req_write_o = breq.write;
    assign req_wdata_o = breq.wdata;
endmodule

// File: rtl/dp_access_checker.sv
module dp_access_checker (
    input logic clk,
    input logic rst,
    input logic update_dr_i,
    input logic orun_det_en_i,
    input logic tdo_o,
    input logic req_o,
    input logic req_ap_o,
    input logic abort_o,
    input logic sticky_err_o,
    input logic sticky_orun_o
);
    // R4: the request is a single-cycle pulse
    a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    // R4: a request only follows an update cycle
    a_r4_req_after_update: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(update_dr_i));

    // R10: no access-port request when a sticky flag was set at update
    a_r10_ap_blocked: assert property (@(posedge clk) disable iff (rst)
        (req_o && req_ap_o) |-> !$past(sticky_err_o || sticky_orun_o));

    // R8: overrun flag rises only from an update with detection enabled
    a_r8_orun_source: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky_orun_o) |-> ($past(update_dr_i) && $past(orun_det_en_i)));

    // R11: sticky flags clear only by an abort update
    a_r11_err_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(sticky_err_o) |-> $past(update_dr_i));

    // R11: abort pulse lasts one cycle
    a_r11_abort_single: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);

    // R2: serial output is always driven
    a_r2_tdo_known: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(tdo_o));
endmodule

bind dp_access_top dp_access_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .update_dr_i   (update_dr_i),
    .orun_det_en_i (orun_det_en_i),
    .tdo_o         (tdo_o),
    .req_o         (req_o),
    .req_ap_o      (req_ap_o),
    .abort_o       (abort_o),
    .sticky_err_o  (sticky_err_o),
    .sticky_orun_o (sticky_orun_o)
);

// File: tb/dp_access_top_test.sv
`timescale 1ns/1ps
module dp_access_top_test;
    localparam logic [31:0] ID = 32'h0C0F_FEE1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ir = 4'h0;
    logic        cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic        orun_en = 1'b0;
    logic        tdo, req, req_ap, req_wr, abort_p, serr, sorun;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata;
    logic        busy = 1'b0, berr = 1'b0;
    logic [31:0] rdata = '0;

    int errors = 0;
    int checks = 0;
    int delay_cfg = 3;
    int req_cnt = 0;
    int abort_cnt = 0;
    logic        last_ap, last_wr;
    logic [1:0]  last_addr;
    logic [31:0] last_wdata;

    always #5 clk = ~clk;

    dp_access_top #(.IDCODE_VAL(ID)) uut (
        .clk(clk), .rst(rst), .ir_i(ir), .capture_dr_i(cap), .shift_dr_i(shf),
        .update_dr_i(upd), .tdi_i(tdi), .tdo_o(tdo), .orun_det_en_i(orun_en),
        .req_o(req), .req_ap_o(req_ap), .req_addr_o(req_addr), .req_write_o(req_wr),
        .req_wdata_o(req_wdata), .abort_o(abort_p), .busy_i(busy), .rdata_i(rdata),
        .error_i(berr), .sticky_err_o(serr), .sticky_orun_o(sorun)
    );

    function automatic logic [31:0] bank_word(input logic ap, input logic [1:0] a);
        return {(ap ? 16'hA5C3 : 16'h5A3C), 14'd0, a};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model plus register-bank stub
    logic [34:0] m_sr;
    logic        m_pend, m_prd, m_ackok, m_serr, m_sorun, m_req, m_abort;
    logic [31:0] m_posted;
    logic        m_ap, m_wr;
    logic [1:0]  m_addr;
    logic [31:0] m_wdata;
    int          stub_cnt;

    always @(posedge clk) begin
        logic [34:0] n_sr;
        logic        n_pend, n_prd, n_ackok, n_serr, n_sorun, n_req, n_abort;
        logic [31:0] n_posted;
        logic        isap, rd;
        if (rst) begin
            m_sr = '0; m_pend = 0; m_prd = 0; m_ackok = 1; m_serr = 0; m_sorun = 0;
            m_req = 0; m_abort = 0; m_posted = '0; m_ap = 0; m_wr = 0; m_addr = 0;
            m_wdata = '0; stub_cnt = 0;
            busy <= 1'b0; rdata <= '0; berr <= 1'b0;
        end else begin
            n_sr = m_sr; n_pend = m_pend; n_prd = m_prd; n_ackok = m_ackok;
            n_serr = m_serr; n_sorun = m_sorun; n_posted = m_posted;
            n_req = 0; n_abort = 0;
            if (m_pend && !m_req && !busy) begin
                n_pend = 0;
                if (m_prd) n_posted = rdata;
                if (berr) n_serr = 1;
            end
            if (cap) begin
                if (ir == 4'h8 || ir == 4'hA || ir == 4'hB)
                    n_sr = {m_posted, (m_pend ? 3'b001 : 3'b010)};
                else if (ir == 4'hE) n_sr = {3'b000, ID};
                else n_sr = '0;
                n_ackok = !m_pend;
            end else if (shf) begin
                n_sr = {tdi, m_sr[34:1]};
            end
            if (upd) begin
                isap = (ir == 4'hB);
                rd = m_sr[0];
                if (ir == 4'hA || ir == 4'hB) begin
                    if (!m_ackok) begin
                        if (orun_en) n_sorun = 1;
                    end else if (!(isap && (m_serr || m_sorun)) &&
                                 !(!isap && rd && m_sr[2:1] == 2'd3)) begin
                        n_req = 1; n_pend = 1; n_prd = rd;
                        m_ap = isap; m_wr = !rd; m_addr = m_sr[2:1]; m_wdata = m_sr[34:3];
                    end
                end else if (ir == 4'h8) begin
                    if (m_sr[3]) begin n_pend = 0; n_abort = 1; end
                    if (m_sr[4]) n_serr = 0;
                    if (m_sr[5]) n_sorun = 0;
                end
            end
            // stub reacts to the design's own pulses
            if (req) begin
                stub_cnt = delay_cfg;
                busy  <= (delay_cfg != 0);
                rdata <= bank_word(req_ap, req_addr);
                berr  <= req_ap && (req_addr == 2'd3);
            end else if (abort_p) begin
                stub_cnt = 0;
                busy <= 1'b0;
            end else if (stub_cnt != 0) begin
                stub_cnt = stub_cnt - 1;
                busy <= (stub_cnt != 0);
            end
            m_sr = n_sr; m_pend = n_pend; m_prd = n_prd; m_ackok = n_ackok;
            m_serr = n_serr; m_sorun = n_sorun; m_posted = n_posted;
            m_req = n_req; m_abort = n_abort;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 tdo", tdo, m_sr[0]);
            chk("R4 req", req, m_req);
            if (m_req) begin
                chk("R4 fields", {req_ap, req_wr, req_addr, req_wdata},
                    {m_ap, m_wr, m_addr, m_wdata});
            end
            chk("R9 sticky_err", serr, m_serr);
            chk("R8 sticky_orun", sorun, m_sorun);
            chk("R11 abort", abort_p, m_abort);
            if (req) begin
                req_cnt++;
                last_ap = req_ap; last_wr = req_wr; last_addr = req_addr; last_wdata = req_wdata;
            end
            if (abort_p) abort_cnt++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic scan(input logic [3:0] irv, input logic [34:0] din, output logic [34:0] dout);
        @(negedge clk); ir = irv; cap = 1'b1;
        @(negedge clk); cap = 1'b0;
        for (int i = 0; i < 35; i++) begin
            shf = 1'b1; tdi = din[i];
            #1 dout[i] = tdo;
            @(negedge clk);
        end
        shf = 1'b0; tdi = 1'b0; upd = 1'b1;
        @(negedge clk); upd = 1'b0;
        idle(2);
    endtask

    function automatic logic [34:0] mk(input logic [31:0] d, input logic [1:0] a, input logic r);
        return {d, a, r};
    endfunction

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [34:0] o;
        int rc;
        idle(3);
        @(negedge clk); rst = 1'b0;
        chk("R8 reset orun", sorun, 0);
        chk("R9 reset err", serr, 0);

        scan(4'hE, '0, o);
        chk("R1 idcode", o[31:0], ID);
        chk("R1 idcode bit0", o[0], 1);

        scan(4'hA, mk(32'h1234_5678, 2'd1, 1'b0), o);
        chk("R3 ack ok after reset", o[2:0], 3'b010);
        chk("R3 posted zero", o[34:3], 0);
        chk("R2 decode", {last_ap, last_wr, last_addr, last_wdata}, {1'b0, 1'b1, 2'd1, 32'h1234_5678});
        idle(10);

        rc = req_cnt;
        scan(4'hB, mk(32'h0, 2'd1, 1'b1), o);
        chk("R4 ap read issued", req_cnt, rc + 1);
        chk("R4 ap flags", {last_ap, last_wr}, 2'b10);
        idle(10);

        rc = req_cnt;
        scan(4'hA, mk(32'h0, 2'd3, 1'b1), o);
        chk("R5 posted word", o[34:3], bank_word(1'b1, 2'd1));
        chk("R5 ack ok", o[2:0], 3'b010);
        scan(4'hA, mk(32'h0, 2'd3, 1'b1), o);
        chk("R6 rdbuf no request", req_cnt, rc);
        chk("R6 posted unchanged", o[34:3], bank_word(1'b1, 2'd1));

        delay_cfg = 200;
        scan(4'hB, mk(32'h0, 2'd2, 1'b1), o);
        rc = req_cnt;
        scan(4'hA, mk(32'hDEAD_0001, 2'd1, 1'b0), o);
        chk("R3 ack wait", o[2:0], 3'b001);
        chk("R7 discarded", req_cnt, rc);
        chk("R8 no orun when disabled", sorun, 0);
        orun_en = 1'b1;
        scan(4'hA, mk(32'hDEAD_0002, 2'd1, 1'b0), o);
        chk("R7 wait again", o[2:0], 3'b001);
        chk("R8 orun set", sorun, 1);
        orun_en = 1'b0;

        rc = abort_cnt;
        scan(4'h8, mk(32'h1, 2'd0, 1'b0), o);
        chk("R11 abort pulse", abort_cnt, rc + 1);
        chk("R11 orun kept", sorun, 1);
        delay_cfg = 3;
        rc = req_cnt;
        scan(4'hB, mk(32'h0, 2'd1, 1'b1), o);
        chk("R11 cancel gives ok", o[2:0], 3'b010);
        chk("R10 ap ignored", req_cnt, rc);
        scan(4'hA, mk(32'h5555_AAAA, 2'd2, 1'b0), o);
        chk("R10 dp still issued", req_cnt, rc + 1);
        idle(10);
        scan(4'h8, mk(32'h4, 2'd0, 1'b0), o);
        chk("R11 orun cleared", sorun, 0);

        scan(4'hB, mk(32'h0, 2'd3, 1'b1), o);
        idle(10);
        chk("R9 error sticky", serr, 1);
        rc = req_cnt;
        scan(4'hB, mk(32'h0, 2'd1, 1'b1), o);
        chk("R10 ap ignored on err", req_cnt, rc);
        scan(4'h8, mk(32'h2, 2'd0, 1'b0), o);
        chk("R11 err cleared", serr, 0);

        rc = req_cnt;
        scan(4'h0, mk(32'h7, 2'd1, 1'b0), o);
        chk("R11 other ir no request", req_cnt, rc);
        chk("R11 other ir stickies", {serr, sorun}, 2'b00);
        scan(4'hA, mk(32'h0, 2'd3, 1'b1), o);
        chk("R5 posted after error read", o[34:3], bank_word(1'b1, 2'd3));

        idle(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule